// File: doc/BRIEF.md
# Super I/O Configuration Register Port

This block is the configuration front end of a multi-function I/O controller. It answers two consecutive byte addresses on an 8-bit I/O bus: the even one selects an index register and the odd one reaches the configuration register that the index names. Three configuration registers sit behind the port. One holds the function enables, one holds the function address selects, and one holds power and test controls. Their current contents are driven out continuously so that neighbouring decoders can place the serial, parallel, floppy and disk functions.

On reset, a 5-bit strap input picks the initial contents of all three registers from a built-in 32-entry table. Until software writes the index, reads of the index address return a short identification sequence. Every accepted data write raises a one-cycle strobe so that downstream logic can pick up the new settings. Setting the lock bit in the power/test register freezes all three registers until the next reset.

Top module: `sio_cfg_port`

## Requirements
- R1: An access hits only when io_addr with bit 0 cleared equals the BASE parameter (default 0x398). On a hit, io_addr[0]=0 selects the index register and io_addr[0]=1 selects the data register. Non-hit writes change nothing, and io_rdata is 0x00 whenever there is no read hit.
- R2: Index values 0, 1 and 2 select the enable, address and power/test registers. A data read with any other index returns 0x00, and a data write with any other index changes nothing.
- R3: After reset, the first index read returns 0x88, the second returns 0x00, and every later index read returns the selected index.
- R4: An index write stores the written byte as the selected index and ends the identification sequence, so the next index read returns that byte.
- R5: While rst_n is low at a clock edge, the selected index is set to 0, the identification sequence restarts, and the registers load from the strap table. Strap 1 gives enable 0x4F, address 0x11, power 0x00. Strap 31 gives 0x00, 0x10, 0x02. Strap 0 gives 0x4F, 0x10, 0x00.
- R6: The outputs cfg_enable, cfg_addr and cfg_power always equal the register contents. A data write appears on them one cycle later, and a data read returns the same value.
- R7: reconf_o is high for exactly the one cycle after each accepted data write, and is low at all other times.
- R8: Bit 6 of the power/test register is the lock. The write that sets it is applied. While it is set, data writes are ignored and produce no strobe, and this lasts until reset.
- R9: The strap input is used only during reset. Changing it later has no effect on the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_i | input | 5 | Reset configuration strap |
| io_addr | input | 16 | Byte address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle io_rd is high |
| cfg_enable | output | 8 | Function enable register |
| cfg_addr | output | 8 | Function address register |
| cfg_power | output | 8 | Power/test register |
| reconf_o | output | 1 | One-cycle pulse after an accepted data write |

## Verification
The assertions assume that io_rd and io_wr are never high together, and that each access lasts exactly one clock cycle. The bench drives at most one strobe per cycle and always returns to idle between operations. Reset is held for at least one edge so that the history checks start from table values. Random traffic mixes hits and misses at both addresses. It keeps lock writes rare, so that most of the run exercises unlocked registers before the lock freezes them.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned NUM_CFG = 3;
   localparam logic [7:0] ID_BYTE0 = 8'h88;
   localparam logic [7:0] ID_BYTE1 = 8'h00;
   localparam int unsigned LOCK_BIT = 6;

   typedef enum logic [1:0] {
      SEL_ENABLE = 2'd0,
      SEL_ADDR   = 2'd1,
      SEL_POWER  = 2'd2
   } cfg_sel_e;

   typedef enum logic [1:0] {
      ID_FIRST  = 2'd0,
      ID_SECOND = 2'd1,
      ID_DONE   = 2'd2
   } id_step_e;

   typedef struct packed {
      logic [7:0] enable;
      logic [7:0] addr;
      logic [7:0] power;
   } cfg_set_t;
endpackage

// File: rtl/sio_strap_rom.sv
module sio_strap_rom
   import sio_cfg_pkg::*;
#(
   parameter int unsigned STRAP_W = 5
) (
   input  logic [STRAP_W-1:0] strap,
   output cfg_set_t           init_set
);
   localparam int unsigned ENTRIES = 1 << STRAP_W;

   initial begin
      if (STRAP_W != 5) $error("sio_strap_rom: table built for 5 strap bits");
   end

   logic [4:0] sel;
   assign sel = strap[4:0];

   always_comb begin
      // enable table: runs of equal values
      if      (sel <= 5'd5)  init_set.enable = 8'h4F;
      else if (sel <= 5'd11) init_set.enable = 8'h4B;
      else if (sel <= 5'd15) init_set.enable = 8'h0F;
      else if (sel <= 5'd19) init_set.enable = 8'h49;
      else if (sel <= 5'd23) init_set.enable = 8'h07;
      else if (sel <= 5'd29) init_set.enable = 8'h47;
      else if (sel == 5'd30) init_set.enable = 8'h08;
      else                   init_set.enable = 8'h00;

      init_set.power = (sel == 5'd31) ? 8'h02 : 8'h00;

      case (sel)
         5'd0:  init_set.addr = 8'h10;  5'd1:  init_set.addr = 8'h11;
         5'd2:  init_set.addr = 8'h11;  5'd3:  init_set.addr = 8'h39;
         5'd4:  init_set.addr = 8'h24;  5'd5:  init_set.addr = 8'h38;
         5'd6:  init_set.addr = 8'h00;  5'd7:  init_set.addr = 8'h01;
         5'd8:  init_set.addr = 8'h01;  5'd9:  init_set.addr = 8'h09;
         5'd10: init_set.addr = 8'h08;  5'd11: init_set.addr = 8'h08;
         5'd12: init_set.addr = 8'h10;  5'd13: init_set.addr = 8'h11;
         5'd14: init_set.addr = 8'h39;  5'd15: init_set.addr = 8'h24;
         5'd16: init_set.addr = 8'h00;  5'd17: init_set.addr = 8'h01;
         5'd18: init_set.addr = 8'h01;  5'd19: init_set.addr = 8'h00;
         5'd20: init_set.addr = 8'h10;  5'd21: init_set.addr = 8'h11;
         5'd22: init_set.addr = 8'h39;  5'd23: init_set.addr = 8'h24;
         5'd24: init_set.addr = 8'h10;  5'd25: init_set.addr = 8'h11;
         5'd26: init_set.addr = 8'h11;  5'd27: init_set.addr = 8'h39;
         5'd28: init_set.addr = 8'h24;  5'd29: init_set.addr = 8'h38;
         default: init_set.addr = 8'h10;
      endcase
   end

   logic unused_entries;
   assign unused_entries = (ENTRIES == 0);
endmodule

// File: rtl/sio_id_seq.sv
module sio_id_seq
   import sio_cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic       idx_rd,
   input  logic [7:0] wdata,
   output logic [7:0] sel_idx,
   output logic [7:0] idx_rdata
);
   id_step_e step_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q  <= ID_FIRST;
         sel_idx <= 8'h00;
      end else if (idx_wr) begin
         step_q  <= ID_DONE;
         sel_idx <= wdata;
      end else if (idx_rd) begin
         case (step_q)
            ID_FIRST:  step_q <= ID_SECOND;
            ID_SECOND: step_q <= ID_DONE;
            default:   step_q <= ID_DONE;
         endcase
      end
   end

   always_comb begin
      case (step_q)
         ID_FIRST:  idx_rdata = ID_BYTE0;
         ID_SECOND: idx_rdata = ID_BYTE1;
         default:   idx_rdata = sel_idx;
      endcase
   end

   AST_ID_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_rd && !idx_wr && idx_rdata == ID_BYTE0 && step_q == ID_FIRST) |=> (idx_rdata == ID_BYTE1 || step_q == ID_SECOND)); // R3
   AST_IDX_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> (idx_rdata == $past(wdata))); // R4
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
   import sio_cfg_pkg::*;
#(
   parameter int unsigned STRAP_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap,
   input  logic               dat_wr,
   input  logic               dat_rd,
   input  logic [7:0]         sel_idx,
   input  logic [7:0]         wdata,
   output cfg_set_t           cfg_q,
   output logic [7:0]         dat_rdata,
   output logic               reconf
);
   cfg_set_t init_set;
   logic     sel_valid;
   logic     locked;
   logic     accept;

   sio_strap_rom #(.STRAP_W(STRAP_W)) u_rom (
      .strap    (strap),
      .init_set (init_set)
   );

   assign sel_valid = (sel_idx < 8'(NUM_CFG));
   assign locked    = cfg_q.power[LOCK_BIT];
   assign accept    = dat_wr && sel_valid && !locked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= init_set;
         reconf <= 1'b0;
      end else begin
         reconf <= accept;
         if (accept) begin
            case (sel_idx[1:0])
               SEL_ENABLE: cfg_q.enable <= wdata;
               SEL_ADDR:   cfg_q.addr   <= wdata;
               default:    cfg_q.power  <= wdata;
            endcase
         end
      end
   end

   always_comb begin
      dat_rdata = 8'h00;
      if (sel_valid) begin
         case (sel_idx[1:0])
            SEL_ENABLE: dat_rdata = cfg_q.enable;
            SEL_ADDR:   dat_rdata = cfg_q.addr;
            default:    dat_rdata = cfg_q.power;
         endcase
      end
   end

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(locked) |-> locked); // R8
   AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(locked) |-> ($stable(cfg_q) && !reconf)); // R8
   AST_BAD_IDX_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_rd && !sel_valid) |-> (dat_rdata == 8'h00)); // R2
   AST_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      reconf |-> $past(dat_wr)); // R7
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
   import sio_cfg_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter logic [15:0] BASE    = 16'h0398,
   parameter int unsigned STRAP_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic [ADDR_W-1:0]  io_addr,
   input  logic               io_wr,
   input  logic               io_rd,
   input  logic [7:0]         io_wdata,
   output logic [7:0]         io_rdata,
   output logic [7:0]         cfg_enable,
   output logic [7:0]         cfg_addr,
   output logic [7:0]         cfg_power,
   output logic               reconf_o
);
   localparam logic [ADDR_W-1:0] BASE_EVEN = ADDR_W'(BASE) & ~ADDR_W'(1);

   initial begin
      if (ADDR_W < 2 || ADDR_W > 16) $error("sio_cfg_port: ADDR_W out of range");
      if (BASE[0] != 1'b0) $error("sio_cfg_port: BASE must be even");
   end

   logic       hit, idx_wr, idx_rd, dat_wr, dat_rd;
   logic [7:0] sel_idx, idx_rdata, dat_rdata;
   cfg_set_t   cfg_q;

   assign hit    = (io_addr[ADDR_W-1:1] == BASE_EVEN[ADDR_W-1:1]);
   assign idx_wr = io_wr && hit && !io_addr[0];
   assign idx_rd = io_rd && hit && !io_addr[0];
   assign dat_wr = io_wr && hit &&  io_addr[0];
   assign dat_rd = io_rd && hit &&  io_addr[0];

   sio_id_seq u_idx (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_wr    (idx_wr),
      .idx_rd    (idx_rd),
      .wdata     (io_wdata),
      .sel_idx   (sel_idx),
      .idx_rdata (idx_rdata)
   );

   sio_cfg_regs #(.STRAP_W(STRAP_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap     (strap_i),
      .dat_wr    (dat_wr),
      .dat_rd    (dat_rd),
      .sel_idx   (sel_idx),
      .wdata     (io_wdata),
      .cfg_q     (cfg_q),
      .dat_rdata (dat_rdata),
      .reconf    (reconf_o)
   );

   always_comb begin
      io_rdata = 8'h00;
      if (idx_rd)      io_rdata = idx_rdata;
      else if (dat_rd) io_rdata = dat_rdata;
   end

   assign cfg_enable = cfg_q.enable;
   assign cfg_addr   = cfg_q.addr;
   assign cfg_power  = cfg_q.power;

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && io_wr)); // R1
   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && hit) |-> (io_rdata == 8'h00)); // R1
   AST_MISS_NOSTROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !hit) |=> !reconf_o); // R7
   AST_RD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_rd && sel_idx == 8'd1) |-> (io_rdata == cfg_addr)); // R6
endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
   localparam logic [15:0] BASE = 16'h0398;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  strap_i = 5'd1;
   logic [15:0] io_addr = 16'h0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0]  io_wdata = 8'h0;
   logic [7:0]  io_rdata, cfg_enable, cfg_addr, cfg_power;
   logic        reconf_o;

   int checks = 0, fails = 0;
   logic [7:0] m_reg [3];
   logic [7:0] m_idx;
   int         m_step;
   bit         done = 0;

   always #10 clk = ~clk;

   sio_cfg_port u_dut (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void strap_exp(input logic [4:0] s);
      case (s)
         5'd0:    begin m_reg[0] = 8'h4F; m_reg[1] = 8'h10; m_reg[2] = 8'h00; end
         5'd1:    begin m_reg[0] = 8'h4F; m_reg[1] = 8'h11; m_reg[2] = 8'h00; end
         default: begin m_reg[0] = 8'h00; m_reg[1] = 8'h10; m_reg[2] = 8'h02; end
      endcase
   endfunction

   task automatic check_outs(string req);
      chk(req, cfg_enable, m_reg[0]);
      chk(req, cfg_addr,   m_reg[1]);
      chk(req, cfg_power,  m_reg[2]);
   endtask

   task automatic do_reset(input logic [4:0] s);
      @(negedge clk);
      rst_n = 1'b0; strap_i = s;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      strap_exp(s); m_idx = 8'h00; m_step = 0;
      check_outs("R5");
   endtask

   task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
      bit hit, acc;
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      hit = (a[15:1] == BASE[15:1]);
      acc = 0;
      if (hit && !a[0]) begin m_idx = d; m_step = 2; end
      else if (hit && a[0] && m_idx < 3 && !m_reg[2][6]) begin m_reg[m_idx] = d; acc = 1; end
      @(negedge clk);
      io_wr = 1'b0;
      chk("R7", reconf_o, acc);
      check_outs("R6");
   endtask

   task automatic bus_rd(input logic [15:0] a, string req);
      logic [7:0] e;
      bit hit;
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      hit = (a[15:1] == BASE[15:1]);
      if (!hit) e = 8'h00;
      else if (a[0]) e = (m_idx < 3) ? m_reg[m_idx] : 8'h00;
      else begin
         e = (m_step == 0) ? 8'h88 : (m_step == 1) ? 8'h00 : m_idx;
         if (m_step < 2) m_step++;
      end
      #2;
      chk(req, io_rdata, e);
      @(negedge clk);
      io_rd = 1'b0;
      chk("R7", reconf_o, 1'b0);
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd4711);
      do_reset(5'd1);
      chk("R7", reconf_o, 1'b0);
      bus_rd(16'h0398, "R3");
      bus_rd(16'h0398, "R3");
      bus_rd(16'h0398, "R3");
      bus_rd(16'h0399, "R2");
      bus_wr(16'h0399, 8'h5A);
      bus_rd(16'h0399, "R6");
      bus_wr(16'h0398, 8'h07);
      bus_rd(16'h0398, "R4");
      bus_wr(16'h0399, 8'hAA);
      bus_rd(16'h0399, "R2");
      bus_wr(16'h039A, 8'h01);
      bus_wr(16'h0396, 8'h02);
      bus_rd(16'h0398, "R1");
      bus_rd(16'h039B, "R1");
      do_reset(5'd31);
      bus_wr(16'h0398, 8'h02);
      bus_rd(16'h0398, "R4");
      do_reset(5'd0);
      strap_i = 5'd31;
      repeat (3) @(negedge clk);
      check_outs("R9");
      bus_wr(16'h0398, 8'h01);
      bus_wr(16'h0399, 8'h3C);
      bus_rd(16'h0399, "R6");
      bus_wr(16'h0398, 8'h02);
      bus_wr(16'h0399, 8'h40);
      bus_wr(16'h0399, 8'h00);
      bus_wr(16'h0398, 8'h00);
      bus_wr(16'h0399, 8'hFF);
      check_outs("R8");
      do_reset(5'd1);
      chk("R8", cfg_power, 8'h00);
      for (int i = 0; i < 400; i++) begin
         int op;
         logic [15:0] a;
         logic [7:0] d;
         op = $urandom_range(0, 9);
         a = ($urandom_range(0, 7) == 0) ? 16'($urandom) : (BASE | 16'($urandom_range(0, 1)));
         d = 8'($urandom);
         if (op < 3) bus_wr(a & 16'hFFFE, 8'($urandom_range(0, 4)));
         else if (op < 6) begin
            if (m_idx == 2 && $urandom_range(0, 15) != 0) d[6] = 1'b0;
            bus_wr(a | 16'h1, d);
         end else bus_rd(a, "R2");
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule